// File: doc/BRIEF.md
# Load/Store Address Generator with Register-Code Aliasing

This block forms the effective address of a load or store: a base operand, plus an index operand shifted left by a small scale, plus a sign-extended displacement. The register values come from the register file unchanged. Two register codes take a special meaning only here, decoded from the register numbers that travel with the values. When code 0 is the base or the index, that operand counts as zero, whatever value arrived with it. When code 31 is the base, that operand becomes the current instruction pointer.

Outside this unit both registers stay ordinary general-purpose registers. The register file and the forwarding paths therefore never need to force anything to zero. The aliasing makes three addressing forms possible without extra opcodes. Base 0 with index 0 gives absolute addressing from the displacement. Base 31 gives addressing relative to the instruction pointer. Index 0 gives base plus displacement.

The result and a valid flag are registered and appear one cycle after the request.

Top module: `agu_alias`

## Requirements
- R1: When the base register number is 0, the base operand is zero, whatever value is supplied on the base value input.
- R2: When the index register number is 0, the index operand is zero, whatever value is supplied on the index value input.
- R3: When the base register number is 31, the base operand is the instruction pointer input instead of the supplied base value.
- R4: With base number 0 and index number 0, the effective address equals the sign-extended displacement alone.
- R5: For any base number other than 0 and 31, and any index number other than 0, the supplied register values are used unchanged.
- R6: Index register number 31 is an ordinary register: its supplied value is used, and the instruction pointer is not substituted.
- R7: The 2-bit scale field shifts the index operand left by its value before the addition: 0 gives ×1, 1 gives ×2, 2 gives ×4 and 3 gives ×8. Bits shifted out above bit 63 are lost.
- R8: The 16-bit displacement is sign-extended from bit 15 to 64 bits, and the 64-bit sum wraps modulo 2^64.
- R9: A request accepted with the valid input high at a rising clock edge shows its address on the address output, with the output valid high, right after that edge.
- R10: After an edge where the valid input is low, the output valid is low and the address output keeps its previous value.
- R11: A synchronous active-high reset clears the output valid at the next rising edge, even if a request is presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| base_num | input | 5 | Base register number |
| base_val | input | 64 | Value read for the base register |
| index_num | input | 5 | Index register number |
| index_val | input | 64 | Value read for the index register |
| ip | input | 64 | Current instruction pointer |
| disp | input | 16 | Signed displacement |
| scale | input | 2 | Index shift amount (0 to 3) |
| ea_vld | output | 1 | Effective address valid |
| ea | output | 64 | Registered effective address |

## Verification
The hardest case to reach is the one where an aliased code arrives with a non-zero value attached. In that case the ports carry a value that the block must discard. The value only shows its effect if the substitution is wrong. The stimulus therefore sweeps every base number against every index number and every scale. Every register number carries a distinct non-zero value, so code 0 and code 31 always bring a value that would visibly change the sum if it were not replaced. Separate requests then drive the sum across the 2^64 boundary, use negative displacements, and shift index bits out above bit 63.

// File: rtl/agu_pkg.sv
package agu_pkg;

    // index shift selector, value equals the left-shift distance
    typedef enum logic [1:0] {
        SHIFT_BY1 = 2'd0,
        SHIFT_BY2 = 2'd1,
        SHIFT_BY4 = 2'd2,
        SHIFT_BY8 = 2'd3
    } agu_shift_e;

endpackage

// File: rtl/agu_base_pick.sv
// Chooses the base operand: zero code, instruction-pointer code, or the
// register value as read.
module agu_base_pick #(
    parameter int ADDR_W  = 64,
    parameter int NUM_W   = 5,
    parameter int ZERO_NO = 0,
    parameter int IPTR_NO = 31
) (
    input  logic [NUM_W-1:0]  num,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [ADDR_W-1:0] iptr,
    output logic [ADDR_W-1:0] opnd
);
    localparam logic [NUM_W-1:0] ZERO_CODE = NUM_W'(ZERO_NO);
    localparam logic [NUM_W-1:0] IPTR_CODE = NUM_W'(IPTR_NO);

    always_comb begin
        if (num == ZERO_CODE) begin
            opnd = '0;
        end else if (num == IPTR_CODE) begin
            opnd = iptr;
        end else begin
            opnd = reg_val;
        end
    end
endmodule

// File: rtl/agu_index_shift.sv
// Zero-forces the index for code 0, then scales it by a power of two.
module agu_index_shift #(
    parameter int ADDR_W  = 64,
    parameter int NUM_W   = 5,
    parameter int SHIFT_W = 2,
    parameter int ZERO_NO = 0
) (
    input  logic [NUM_W-1:0]   num,
    input  logic [ADDR_W-1:0]  reg_val,
    input  logic [SHIFT_W-1:0] shift,
    output logic [ADDR_W-1:0]  opnd
);
    localparam int               NUM_SHIFTS = 1 << SHIFT_W;
    localparam logic [NUM_W-1:0] ZERO_CODE  = NUM_W'(ZERO_NO);

    logic [ADDR_W-1:0] masked;
    logic [ADDR_W-1:0] shifted [NUM_SHIFTS];

    always_comb begin
        masked = (num == ZERO_CODE) ? '0 : reg_val;
    end

    for (genvar s = 0; s < NUM_SHIFTS; s++) begin : g_shift
        assign shifted[s] = masked << s;
    end

    always_comb begin
        opnd = shifted[shift];
    end
endmodule

// File: rtl/agu_sum3.sv
// Three-operand modular adder with displacement sign extension.
module agu_sum3 #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base_opnd,
    input  logic [ADDR_W-1:0] index_opnd,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] sum
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_wide;

    always_comb begin
        disp_wide = {{EXT_W{disp[DISP_W-1]}}, disp};
        sum       = base_opnd + index_opnd + disp_wide;
    end
endmodule

// File: rtl/agu_alias.sv
module agu_alias #(
    parameter int ADDR_W  = 64,
    parameter int NUM_W   = 5,
    parameter int DISP_W  = 16,
    parameter int SHIFT_W = 2,
    parameter int ZERO_NO = 0,
    parameter int IPTR_NO = 31
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_vld,
    input  logic [NUM_W-1:0]   base_num,
    input  logic [ADDR_W-1:0]  base_val,
    input  logic [NUM_W-1:0]   index_num,
    input  logic [ADDR_W-1:0]  index_val,
    input  logic [ADDR_W-1:0]  ip,
    input  logic [DISP_W-1:0]  disp,
    input  logic [SHIFT_W-1:0] scale,
    output logic               ea_vld,
    output logic [ADDR_W-1:0]  ea
);
    import agu_pkg::*;

    localparam int               EXT_W     = ADDR_W - DISP_W;
    localparam logic [NUM_W-1:0] ZERO_CODE = NUM_W'(ZERO_NO);
    localparam logic [NUM_W-1:0] IPTR_CODE = NUM_W'(IPTR_NO);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
    } out_state_t;

    out_state_t        st_d, st_q;
    logic [ADDR_W-1:0] base_opnd;
    logic [ADDR_W-1:0] index_opnd;
    logic [ADDR_W-1:0] addr_sum;

    agu_base_pick #(
        .ADDR_W (ADDR_W),
        .NUM_W  (NUM_W),
        .ZERO_NO(ZERO_NO),
        .IPTR_NO(IPTR_NO)
    ) u_base (
        .num    (base_num),
        .reg_val(base_val),
        .iptr   (ip),
        .opnd   (base_opnd)
    );

    agu_index_shift #(
        .ADDR_W (ADDR_W),
        .NUM_W  (NUM_W),
        .SHIFT_W(SHIFT_W),
        .ZERO_NO(ZERO_NO)
    ) u_index (
        .num    (index_num),
        .reg_val(index_val),
        .shift  (scale),
        .opnd   (index_opnd)
    );

    agu_sum3 #(
        .ADDR_W(ADDR_W),
        .DISP_W(DISP_W)
    ) u_sum (
        .base_opnd (base_opnd),
        .index_opnd(index_opnd),
        .disp      (disp),
        .sum       (addr_sum)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_vld;
        if (req_vld) begin
            st_d.addr = addr_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.vld  <= 1'b0;
            st_q.addr <= st_q.addr;
        end else begin
            st_q <= st_d;
        end
    end

    assign ea_vld = st_q.vld;
    assign ea     = st_q.addr;

    // R9
    vld_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_vld |=> ea_vld);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_vld |=> (!ea_vld && $stable(ea)));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> !ea_vld);

    // R4
    absolute_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && base_num == ZERO_CODE && index_num == ZERO_CODE)
        |=> (ea == $past({{EXT_W{disp[DISP_W-1]}}, disp})));

    // R3
    iptr_base_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && base_num == IPTR_CODE && index_num == ZERO_CODE)
        |=> (ea == $past(ip + {{EXT_W{disp[DISP_W-1]}}, disp})));

    // R1
    zero_base_chk: assert property (@(posedge clk) disable iff (rst)
        (req_vld && base_num == ZERO_CODE && scale == SHIFT_BY1)
        |=> (ea == $past(((index_num == ZERO_CODE) ? '0 : index_val)
                         + {{EXT_W{disp[DISP_W-1]}}, disp})));
endmodule

// File: tb/sim_agu_alias.sv
module sim_agu_alias;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_vld;
    logic [4:0]  base_num;
    logic [63:0] base_val;
    logic [4:0]  index_num;
    logic [63:0] index_val;
    logic [63:0] ip;
    logic [15:0] disp;
    logic [1:0]  scale;
    logic        ea_vld;
    logic [63:0] ea;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    agu_alias u0 (
        .clk      (clk),
        .rst      (rst),
        .req_vld  (req_vld),
        .base_num (base_num),
        .base_val (base_val),
        .index_num(index_num),
        .index_val(index_val),
        .ip       (ip),
        .disp     (disp),
        .scale    (scale),
        .ea_vld   (ea_vld),
        .ea       (ea)
    );

    function automatic logic [63:0] model(input logic [4:0] bn, input logic [63:0] bv,
                                          input logic [4:0] xn, input logic [63:0] xv,
                                          input logic [63:0] ipv, input logic [15:0] d,
                                          input logic [1:0] sc);
        logic [63:0] b, x;
        b = (bn == 5'd0) ? 64'd0 : (bn == 5'd31) ? ipv : bv;
        x = (xn == 5'd0) ? 64'd0 : xv;
        return b + (x << sc) + {{48{d[15]}}, d};
    endfunction

    function automatic logic [63:0] bval_of(input int n);
        return (64'h0123_4567_89AB_CDEF * 64'(n + 1)) ^ 64'h8000_0000_0000_0000;
    endfunction

    function automatic logic [63:0] xval_of(input int n);
        return 64'hFEDC_BA98_7654_3210 + 64'(n) * 64'h0000_0101_0000_0003;
    endfunction

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [4:0] bn, input logic [63:0] bv,
                         input logic [4:0] xn, input logic [63:0] xv,
                         input logic [15:0] d, input logic [1:0] sc, input string tag);
        logic [63:0] exp;
        @(negedge clk);
        req_vld = 1'b1; base_num = bn; base_val = bv;
        index_num = xn; index_val = xv; disp = d; scale = sc;
        exp = model(bn, bv, xn, xv, ip, d, sc);
        @(negedge clk);
        cmp({tag, " R9 vld"}, 64'(ea_vld), 64'd1);
        cmp(tag, ea, exp);
        req_vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; req_vld = 1'b0; base_num = '0; base_val = '0;
        index_num = '0; index_val = '0; disp = '0; scale = '0;
        ip = 64'h0000_7FFF_C000_1230;
        repeat (3) @(negedge clk);
        cmp("R11 reset vld", 64'(ea_vld), 64'd0);
        rst = 1'b0;

        // full sweep of register codes and scales
        for (int bn = 0; bn < 32; bn++) begin
            for (int xn = 0; xn < 32; xn++) begin
                for (int sc = 0; sc < 4; sc++) begin
                    string tag;
                    if (bn == 0 && xn == 0)  tag = "R4 absolute";
                    else if (bn == 0)        tag = "R1 zero base";
                    else if (bn == 31)       tag = "R3 ip base";
                    else if (xn == 0)        tag = "R2 zero index";
                    else if (xn == 31)       tag = "R6 index 31";
                    else                     tag = "R5 plain";
                    issue(5'(bn), bval_of(bn), 5'(xn), xval_of(xn),
                          16'(bn * 1031 + xn * 97 + sc * 7919), 2'(sc), tag);
                end
            end
        end

        // R7: each scale with a single index bit, top bit shifted out
        for (int sc = 0; sc < 4; sc++) begin
            issue(5'd0, 64'hFFFF, 5'd3, 64'h1, 16'd0, 2'(sc), "R7 scale");
            cmp("R7 scale value", ea, 64'd1 << sc);
        end
        issue(5'd0, 64'd0, 5'd4, 64'h8000_0000_0000_0001, 16'd0, 2'd3, "R7 overflow");
        cmp("R7 overflow value", ea, 64'h8);

        // R8: negative displacement and wrap
        issue(5'd5, 64'h10, 5'd0, 64'h0, 16'hFFF0, 2'd0, "R8 neg disp");
        cmp("R8 neg disp value", ea, 64'h0);
        issue(5'd6, 64'hFFFF_FFFF_FFFF_FFF0, 5'd7, 64'h4, 16'h0010, 2'd2, "R8 wrap");
        cmp("R8 wrap value", ea, 64'h10);
        issue(5'd0, 64'd1, 5'd0, 64'd1, 16'h8000, 2'd0, "R8 R4 min disp");
        cmp("R8 min disp value", ea, 64'hFFFF_FFFF_FFFF_8000);

        // R10: idle cycle clears valid, keeps address
        issue(5'd9, 64'h1234, 5'd10, 64'h10, 16'h1, 2'd1, "R10 setup");
        held = ea;
        base_num = 5'd2; base_val = 64'hDEAD; disp = 16'h7777;
        @(negedge clk);
        cmp("R10 idle vld", 64'(ea_vld), 64'd0);
        cmp("R10 idle addr", ea, held);

        // R11: reset wins over a presented request
        @(negedge clk);
        req_vld = 1'b1; rst = 1'b1;
        @(negedge clk);
        cmp("R11 reset with req", 64'(ea_vld), 64'd0);
        rst = 1'b0; req_vld = 1'b0;
        @(negedge clk);
        finish_run();
    end
endmodule